// File: doc/BRIEF.md
# Sequenced Double-Buffered Synthesizer Parameter Bank

This block holds the loop parameters for a clock synthesizer behind an indexed host port. The host first writes an index to the index address (3D6h). It then reads or writes the selected register through the data address (3D7h). The four parameter registers at indices C4h, C5h, C6h and C7h are the multiplier, the low byte of the divider, and two more loop parameters. Each host write lands in shadow storage.

The parameters that drive the synthesizer are held in a separate active copy. That copy changes only when the host has written all four registers in strictly ascending index order. All four values then move across in a single clock, and an update strobe fires. Between complete sequences the synthesizer sees a steady parameter set. A single copy serves every display pipeline.

Top module: `clk_param_bank`

## Requirements
- R1: While reset is high and after it is released, the active outputs and the shadow registers hold the DEFAULTS parameter (slot k at bits k*8 +: 8, default slots 2Ah, 3Ch, 05h, 01h), the index register reads 00h, and the update strobe is low.
- R2: A write to address 3D6h loads the index register. A read of 3D6h returns the index on `rdata` one cycle after the read strobe.
- R3: A data write (address 3D7h) while the index is C4h+k, k in 0..3, stores the byte in shadow slot k. A read of 3D7h returns that shadow slot one cycle later. A read of any other index returns 00h, and `rdata` is 00h in every cycle that does not follow a read strobe.
- R4: The active outputs never change except in a cycle where the update strobe is high.
- R5: After data writes to C4h, C5h, C6h and C7h in that order, the cycle after the C7h write shows all four shadow values on the active outputs, including the byte just written, and the update strobe is high.
- R6: A data write to C4h always starts a fresh sequence, whether or not one is already in progress.
- R7: A data write to C5h, C6h or C7h that is not the next slot expected aborts the sequence. No commit follows until a new sequence starts at C4h.
- R8: These do not disturb a sequence in progress: index writes, data writes while the index is outside C4h-C7h, and writes to other addresses. Data written while the index is outside C4h-C7h is not stored.
- R9: The update strobe is high for exactly one cycle per commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Host I/O address |
| wdata | input | 8 | Host write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data, valid one cycle after `rd` |
| act_params | output | 32 | Active parameters, slot k at bits k*8 +: 8 |
| upd_pulse | output | 1 | One-cycle strobe when the active set is replaced |

## Verification
The assertions check three things on every cycle: the active outputs move only with the update strobe, a committed set equals the shadow contents, and the strobe never lasts two cycles. They also check that the sequence tracker restarts on C4h and drops back to idle on an out-of-order write. Whether a commit happens at the right moment depends on the history of host accesses. Only the bench scenarios can show that: aborts, restarts, stray index traffic in the middle of a sequence, and random access mixes checked against a reference model.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;
  typedef enum logic [1:0] {
    SEQ_NONE,
    SEQ_START,
    SEQ_ADVANCE,
    SEQ_ABORT
  } seq_ev_t;
endpackage

// File: rtl/host_decode.sv
module host_decode #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NUM_REGS = 4,
  parameter int SLOT_W = 2,
  parameter logic [AW-1:0] IDX_ADDR = AW'(16'h03D6),
  parameter logic [AW-1:0] DATA_ADDR = AW'(16'h03D7),
  parameter logic [DW-1:0] BASE_IDX = DW'(8'hC4)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [NUM_REGS*DW-1:0] shadow_flat,
  output logic                   grp_wr,
  output logic [SLOT_W-1:0]      slot,
  output logic [DW-1:0]          rdata
);
  localparam logic [DW-1:0] NREG_V = DW'(NUM_REGS);

  logic [DW-1:0] idx_q;
  logic [DW-1:0] off;
  logic          grp_hit;

  assign off     = idx_q - BASE_IDX;
  assign grp_hit = (idx_q >= BASE_IDX) && (off < NREG_V);
  assign slot    = off[SLOT_W-1:0];
  assign grp_wr  = wr && (addr == DATA_ADDR) && grp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (wr && addr == IDX_ADDR) begin
      idx_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd && addr == IDX_ADDR) begin
      rdata <= idx_q;
    end else if (rd && addr == DATA_ADDR && grp_hit) begin
      rdata <= shadow_flat[slot*DW +: DW];
    end else begin
      rdata <= '0;
    end
  end

  // R3: read data is zero unless a read was requested the cycle before
  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rd) |-> rdata == '0);
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
  import pll_regs_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_wr,
  input  logic [SLOT_W-1:0] slot,
  output logic              commit_now,
  output logic              upd_pulse
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_REGS - 1);

  logic [SLOT_W-1:0] pos_q;
  seq_ev_t           ev;

  always_comb begin
    ev = SEQ_NONE;
    if (grp_wr) begin
      if (slot == '0)        ev = SEQ_START;
      else if (slot == pos_q) ev = SEQ_ADVANCE;
      else                    ev = SEQ_ABORT;
    end
  end

  assign commit_now = (ev == SEQ_ADVANCE) && (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= commit_now;
      unique case (ev)
        SEQ_START:   pos_q <= SLOT_W'(1);
        SEQ_ADVANCE: pos_q <= (slot == LAST) ? '0 : pos_q + SLOT_W'(1);
        SEQ_ABORT:   pos_q <= '0;
        default:     pos_q <= pos_q;
      endcase
    end
  end

  // R6: a write to the first slot always leaves the tracker expecting the second
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (grp_wr && slot == '0) |=> pos_q == SLOT_W'(1));

  // R7: an unexpected slot returns the tracker to idle
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (grp_wr && slot != '0 && slot != pos_q) |=> (pos_q == '0 && !upd_pulse));

  // R8: without a group write the tracker holds its position
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !grp_wr |=> $stable(pos_q));

  // R9: strobe never lasts two cycles
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);
endmodule

// File: rtl/param_store.sv
module param_store #(
  parameter int DW = 8,
  parameter int NUM_REGS = 4,
  parameter int SLOT_W = 2,
  parameter logic [NUM_REGS*DW-1:0] DEFAULTS = 32'h0105_3C2A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   grp_wr,
  input  logic [SLOT_W-1:0]      slot,
  input  logic [DW-1:0]          wdata,
  input  logic                   commit_now,
  output logic [NUM_REGS*DW-1:0] shadow_flat,
  output logic [NUM_REGS*DW-1:0] act_params
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    logic [DW-1:0] shadow_q;
    logic          hit;

    assign hit = grp_wr && (slot == SLOT_W'(k));

    always_ff @(posedge clk) begin
      if (rst)      shadow_q <= DEFAULTS[k*DW +: DW];
      else if (hit) shadow_q <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)             act_params[k*DW +: DW] <= DEFAULTS[k*DW +: DW];
      else if (commit_now) act_params[k*DW +: DW] <= hit ? wdata : shadow_q;
    end

    assign shadow_flat[k*DW +: DW] = shadow_q;
  end

  // R4: active set moves only on a commit request
  assert_active_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !commit_now |=> $stable(act_params));
endmodule

// File: rtl/clk_param_bank.sv
module clk_param_bank #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NUM_REGS = 4,
  parameter logic [AW-1:0] IDX_ADDR = AW'(16'h03D6),
  parameter logic [AW-1:0] DATA_ADDR = AW'(16'h03D7),
  parameter logic [DW-1:0] BASE_IDX = DW'(8'hC4),
  parameter logic [NUM_REGS*DW-1:0] DEFAULTS = 32'h0105_3C2A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   wr,
  input  logic                   rd,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] act_params,
  output logic                   upd_pulse
);
  localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                   grp_wr;
  logic [SLOT_W-1:0]      slot;
  logic                   commit_now;
  logic [NUM_REGS*DW-1:0] shadow_flat;

  host_decode #(
    .AW(AW), .DW(DW), .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W),
    .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR), .BASE_IDX(BASE_IDX)
  ) i_decode (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .shadow_flat(shadow_flat), .grp_wr(grp_wr), .slot(slot), .rdata(rdata)
  );

  seq_tracker #(.NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)) i_tracker (
    .clk(clk), .rst(rst), .grp_wr(grp_wr), .slot(slot),
    .commit_now(commit_now), .upd_pulse(upd_pulse)
  );

  param_store #(
    .DW(DW), .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W), .DEFAULTS(DEFAULTS)
  ) i_store (
    .clk(clk), .rst(rst), .grp_wr(grp_wr), .slot(slot), .wdata(wdata),
    .commit_now(commit_now), .shadow_flat(shadow_flat), .act_params(act_params)
  );

  // R4: outputs seen by the synthesizer change only with the strobe
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |-> $stable(act_params));

  // R5: a committed set is exactly the shadow contents
  assert_commit_copy_R5: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> act_params == shadow_flat);
endmodule

// File: tb/test_clk_param_bank.sv
module test_clk_param_bank;
  localparam logic [15:0] IA = 16'h03D6;
  localparam logic [15:0] DA = 16'h03D7;
  localparam logic [31:0] DEF = 32'h0105_3C2A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [31:0] act_params;
  logic        upd_pulse;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_idx;
  logic [7:0] m_sh [4];
  logic [7:0] m_act [4];
  int         m_pos;
  logic       m_pulse;

  clk_param_bank i_clk_param_bank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .act_params(act_params), .upd_pulse(upd_pulse)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] flat_act();
    return {m_act[3], m_act[2], m_act[1], m_act[0]};
  endfunction

  function automatic logic in_grp(logic [7:0] i);
    return (i >= 8'hC4) && (i <= 8'hC7);
  endfunction

  task automatic check(logic ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    m_pulse = 1'b0;
    if (a == IA) m_idx = d;
    else if (a == DA && in_grp(m_idx)) begin
      int s = int'(m_idx - 8'hC4);
      m_sh[s] = d;
      if (s == 0) m_pos = 1;
      else if (s == m_pos) begin
        if (s == 3) begin
          m_pos = 0;
          m_pulse = 1'b1;
          for (int k = 0; k < 4; k++) m_act[k] = m_sh[k];
        end else m_pos = s + 1;
      end else m_pos = 0;
    end
  endtask

  task automatic host_wr(logic [15:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
    check(upd_pulse == m_pulse, {tag, " strobe"}, 32'(upd_pulse), 32'(m_pulse));
    check(act_params == flat_act(), {tag, " active"}, act_params, flat_act());
  endtask

  task automatic host_rd(logic [15:0] a, string tag);
    logic [7:0] exp;
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    if (a == IA) exp = m_idx;
    else if (a == DA && in_grp(m_idx)) exp = m_sh[int'(m_idx - 8'hC4)];
    else exp = 8'h00;
    check(rdata == exp, tag, 32'(rdata), 32'(exp));
  endtask

  task automatic seq_data(logic [7:0] i, logic [7:0] d, string tag);
    host_wr(IA, i, tag);
    host_wr(DA, d, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_idx = 8'h00; m_pos = 0; m_pulse = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_sh[k] = DEF[k*8 +: 8];
      m_act[k] = DEF[k*8 +: 8];
    end
    repeat (3) @(negedge clk);
    check(act_params == DEF && !upd_pulse, "R1 during reset", act_params, DEF);
    rst = 1'b0;
    @(negedge clk);
    check(act_params == DEF, "R1 active after reset", act_params, DEF);
    check(!upd_pulse, "R1 strobe after reset", 32'(upd_pulse), 32'd0);
    check(rdata == 8'h00, "R3 idle rdata", 32'(rdata), 32'd0);
    host_rd(IA, "R1 index reads zero");
    for (int k = 0; k < 4; k++) begin
      host_wr(IA, 8'(8'hC4 + k), "R2 select");
      host_rd(DA, "R1 shadow default");
    end
    host_rd(IA, "R2 index readback");
    host_wr(IA, 8'hC9, "R2 select outside");
    host_rd(DA, "R3 outside reads zero");

    // R5: complete ordered sequence
    seq_data(8'hC4, 8'h11, "R5 m");
    seq_data(8'hC5, 8'h22, "R5 n");
    seq_data(8'hC6, 8'h33, "R5 p2");
    seq_data(8'hC7, 8'h44, "R5 p3 commit");
    check(act_params == 32'h4433_2211, "R5 active set", act_params, 32'h4433_2211);
    @(negedge clk);
    check(!upd_pulse, "R9 strobe single cycle", 32'(upd_pulse), 32'd0);

    // R7: skip C6, abort
    seq_data(8'hC4, 8'h51, "R7 m");
    seq_data(8'hC5, 8'h52, "R7 n");
    seq_data(8'hC7, 8'h53, "R7 skip");
    check(act_params == 32'h4433_2211, "R7 no commit", act_params, 32'h4433_2211);
    seq_data(8'hC6, 8'h54, "R7 late");
    seq_data(8'hC7, 8'h55, "R7 still aborted");
    host_wr(IA, 8'hC5, "R3 select");
    host_rd(DA, "R3 shadow kept");

    // R6: restart mid-sequence
    seq_data(8'hC4, 8'h61, "R6 m");
    seq_data(8'hC5, 8'h62, "R6 n");
    seq_data(8'hC4, 8'h63, "R6 restart");
    seq_data(8'hC5, 8'h64, "R6 n2");
    seq_data(8'hC6, 8'h65, "R6 p2");
    seq_data(8'hC7, 8'h66, "R6 commit");
    check(act_params == 32'h6665_6463, "R6 active set", act_params, 32'h6665_6463);

    // R8: stray traffic inside a sequence
    seq_data(8'hC4, 8'h71, "R8 m");
    seq_data(8'hC8, 8'hEE, "R8 outside data");
    host_wr(16'h03D5, 8'hC7, "R8 other address");
    host_rd(DA, "R8 outside read");
    seq_data(8'hC5, 8'h72, "R8 n");
    seq_data(8'h00, 8'hEE, "R8 outside data 2");
    seq_data(8'hC6, 8'h73, "R8 p2");
    seq_data(8'hC7, 8'h74, "R8 commit");
    check(act_params == 32'h7473_7271, "R8 active set", act_params, 32'h7473_7271);

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom_range(0, 4));
      case (op)
        0: host_wr(IA, 8'(8'hC3 + $urandom_range(0, 5)), "R8 random index");
        1, 2: host_wr(DA, 8'($urandom), "R5 random data");
        3: host_rd(DA, "R3 random read");
        default: host_rd(IA, "R2 random index read");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule